// File: doc/BRIEF.md
# VLIW Execute Packet Dispatcher

This block sits between instruction fetch and decode in a very-long-instruction-word core. It accepts a fetch packet of `NSLOT` instruction slots of `IW` bits each (eight slots of 32 bits by default). Bit 0 of every instruction is a chaining flag that tells the block whether the next slot runs in the same cycle. From the chain flags the block cuts the fetch packet into execute packets. It issues exactly one execute packet per non-stalled cycle on a set of per-lane valid and instruction outputs.

A fetch packet is held until its last execute packet has been issued, and only then is the next one requested. Execute packets never span two fetch packets, because the final slot always closes a packet. Downstream logic can freeze issue with a hold input. While the hold input is high, nothing is issued and the position inside the held fetch packet does not move.

Top module: `vliw_ep_dispatch`

## Requirements
- R1: While reset is active, and after it until the first fetch packet is accepted, no lane is valid and `fetch_req` is high.
- R2: An instruction whose bit 0 is 1 (and which is not in the final slot) is issued in the same cycle as the instruction in the next slot.
- R3: An instruction whose bit 0 is 0 ends its execute packet. The instruction in the next slot is issued in the next non-stalled cycle.
- R4: The final slot (`NSLOT-1`) always ends an execute packet, whatever its bit 0 holds. The next execute packet comes from the next fetch packet and starts at lane 0.
- R5: `fetch_req` is low while any execute packet of the held fetch packet is still to be issued. It is high in the cycle after the execute packet containing the final slot has been issued. A packet is accepted on a clock edge where `fetch_req` and `fetch_valid` are both high.
- R6: While `hold_in` is high, no lane is valid and the issue position is held. After the hold, issue resumes with the same execute packet, with none lost or repeated.
- R7: The instruction in fetch slot k appears on output lane k. The valid lanes of one cycle form one contiguous run in ascending slot order.
- R8: At most one execute packet is issued per cycle. A fetch packet with N packet-ending slots yields exactly N execute packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fetch_req | output | 1 | High when the block can take a new fetch packet |
| fetch_valid | input | 1 | Fetch packet present on `fetch_word` |
| fetch_word | input | NSLOT*IW | Fetch packet; slot k occupies bits k*IW+IW-1 down to k*IW |
| hold_in | input | 1 | Downstream stall; freezes issue |
| lane_valid | output | NSLOT | Per-lane valid of the execute packet issued this cycle |
| lane_instr | output | NSLOT*IW | Per-lane instruction; lane k occupies bits k*IW+IW-1 down to k*IW |

## Verification
The bench builds the block with its default eight slots of 32 bits. With that size, every chain pattern of a fetch packet can be written out by hand and checked in a few cycles. This covers the single eight-wide packet, eight single-instruction packets, and a chain flag set in the final slot. Random chain patterns combined with random hold cycles then test hold against every issue position, including the final execute packet and the cycle just after a fetch packet is accepted.

// File: rtl/vliw_ep_pkg.sv
package vliw_ep_pkg;

  typedef enum logic {
    BUF_EMPTY = 1'b0,
    BUF_FULL  = 1'b1
  } buf_state_e;

endpackage

// File: rtl/ep_rst_sync.sv
module ep_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/ep_run_finder.sv
module ep_run_finder #(
  parameter int NSLOT = 8,
  parameter int IW    = 32,
  localparam int PW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic [NSLOT*IW-1:0] pkt,
  input  logic [PW-1:0]       pos,
  output logic [NSLOT-1:0]    run_mask,
  output logic [PW-1:0]       run_end,
  output logic                run_last
);

  logic [NSLOT-1:0] stop_bit;

  // A slot closes its run when its chain flag is clear or it is the final slot.
  for (genvar k = 0; k < NSLOT; k++) begin : g_stop
    if (k == NSLOT - 1) begin : g_final
      assign stop_bit[k] = 1'b1;
    end else begin : g_inner
      assign stop_bit[k] = ~pkt[k*IW];
    end
  end

  always_comb begin
    logic closed;
    closed   = 1'b0;
    run_mask = '0;
    run_end  = pos;
    for (int j = 0; j < NSLOT; j++) begin
      if ((PW'(j) >= pos) && !closed) begin
        run_mask[j] = 1'b1;
        run_end     = PW'(j);
        if (stop_bit[j]) begin
          closed = 1'b1;
        end
      end
    end
  end

  assign run_last = run_mask[NSLOT-1];

endmodule

// File: rtl/ep_fetch_buffer.sv
module ep_fetch_buffer
  import vliw_ep_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int IW    = 32,
  localparam int PW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en,
  input  logic [NSLOT*IW-1:0] load_word,
  input  logic                adv_en,
  input  logic [PW-1:0]       adv_end,
  input  logic                adv_last,
  output logic                held,
  output logic [NSLOT*IW-1:0] pkt,
  output logic [PW-1:0]       pos
);

  buf_state_e          state_q, state_d;
  logic [NSLOT*IW-1:0] pkt_q, pkt_d;
  logic [PW-1:0]       pos_q, pos_d;
  logic                pkt_en;

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    pkt_d   = pkt_q;
    pkt_en  = 1'b0;
    if (load_en) begin
      state_d = BUF_FULL;
      pos_d   = '0;
      pkt_d   = load_word;
      pkt_en  = 1'b1;
    end else if (adv_en) begin
      if (adv_last) begin
        state_d = BUF_EMPTY;
        pos_d   = '0;
      end else begin
        pos_d   = adv_end + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BUF_EMPTY;
      pos_q   <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
    end
  end

  // Data path register: enabled load only, no reset needed.
  always_ff @(posedge clk) begin
    if (pkt_en) begin
      pkt_q <= pkt_d;
    end
  end

  assign held = (state_q == BUF_FULL);
  assign pkt  = pkt_q;
  assign pos  = pos_q;

endmodule

// File: rtl/vliw_ep_dispatch.sv
module vliw_ep_dispatch #(
  parameter int NSLOT = 8,
  parameter int IW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                fetch_req,
  input  logic                fetch_valid,
  input  logic [NSLOT*IW-1:0] fetch_word,
  input  logic                hold_in,
  output logic [NSLOT-1:0]    lane_valid,
  output logic [NSLOT*IW-1:0] lane_instr
);

  localparam int PW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic                rst_n_sync;
  logic                held;
  logic [NSLOT*IW-1:0] pkt;
  logic [PW-1:0]       pos;
  logic [NSLOT-1:0]    run_mask;
  logic [PW-1:0]       run_end;
  logic                run_last;
  logic                accept;
  logic                issue;

  ep_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  ep_fetch_buffer #(.NSLOT(NSLOT), .IW(IW)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .load_en   (accept),
    .load_word (fetch_word),
    .adv_en    (issue),
    .adv_end   (run_end),
    .adv_last  (run_last),
    .held      (held),
    .pkt       (pkt),
    .pos       (pos)
  );

  ep_run_finder #(.NSLOT(NSLOT), .IW(IW)) u_run (
    .pkt      (pkt),
    .pos      (pos),
    .run_mask (run_mask),
    .run_end  (run_end),
    .run_last (run_last)
  );

  assign fetch_req = ~held;
  assign accept    = fetch_req & fetch_valid;
  assign issue     = held & ~hold_in;

  for (genvar k = 0; k < NSLOT; k++) begin : g_lane
    assign lane_valid[k]            = issue & run_mask[k];
    assign lane_instr[k*IW +: IW]   = lane_valid[k] ? pkt[k*IW +: IW] : '0;
  end

endmodule

// File: rtl/vliw_ep_dispatch_chk.sv
module vliw_ep_dispatch_chk #(
  parameter int NSLOT = 8,
  parameter int IW    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fetch_req,
  input logic                fetch_valid,
  input logic [NSLOT*IW-1:0] fetch_word,
  input logic                hold_in,
  input logic [NSLOT-1:0]    lane_valid,
  input logic [NSLOT*IW-1:0] lane_instr
);

  // R6
  hold_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_in |-> (lane_valid == '0));

  // R5
  req_only_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (lane_valid == '0));

  // R4
  final_lane_frees_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_valid[NSLOT-1] |=> fetch_req);

  // R5
  accept_starts_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_valid) |=> (hold_in || lane_valid[0]));

  for (genvar k = 0; k < NSLOT - 1; k++) begin : g_pair
    // R2
    chain_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_valid[k] && lane_instr[k*IW]) |-> lane_valid[k+1]);
    // R3
    break_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_valid[k] && !lane_instr[k*IW]) |-> !lane_valid[k+1]);
    // R7
    run_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_valid[k+1] && !lane_valid[k]) |-> ((lane_valid & ((NSLOT)'(1) << k) - (NSLOT)'(1)) == '0));
  end

endmodule

bind vliw_ep_dispatch vliw_ep_dispatch_chk #(.NSLOT(NSLOT), .IW(IW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_req   (fetch_req),
  .fetch_valid (fetch_valid),
  .fetch_word  (fetch_word),
  .hold_in     (hold_in),
  .lane_valid  (lane_valid),
  .lane_instr  (lane_instr)
);

// File: tb/vliw_ep_dispatch_tb.sv
module vliw_ep_dispatch_tb;

  localparam int NSLOT = 8;
  localparam int IW    = 32;
  localparam int FW    = NSLOT * IW;

  typedef struct {
    logic [NSLOT-1:0] mask;
    logic [FW-1:0]    word;
  } ep_item_t;

  logic            clk;
  logic            rst_n;
  logic            fetch_req;
  logic            fetch_valid;
  logic [FW-1:0]   fetch_word;
  logic            hold_in;
  logic [NSLOT-1:0] lane_valid;
  logic [FW-1:0]   lane_instr;

  int checks;
  int errors;
  bit mon_en;
  bit rand_hold;
  ep_item_t exp_q[$];

  vliw_ep_dispatch #(.NSLOT(NSLOT), .IW(IW)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_req   (fetch_req),
    .fetch_valid (fetch_valid),
    .fetch_word  (fetch_word),
    .hold_in     (hold_in),
    .lane_valid  (lane_valid),
    .lane_instr  (lane_instr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [FW-1:0] make_fp(input logic [NSLOT-1:0] chain, input int tag);
    logic [FW-1:0] w;
    for (int k = 0; k < NSLOT; k++) begin
      w[k*IW +: IW] = {16'(tag), 8'(k), 7'(k * 5 + tag), chain[k]};
    end
    return w;
  endfunction

  // Driver: expected execute packets follow the chain rules, pushed in issue order.
  task automatic send_fp(input logic [FW-1:0] w);
    int start;
    start = 0;
    for (int j = 0; j < NSLOT; j++) begin
      if (!w[j*IW] || j == NSLOT - 1) begin
        ep_item_t it;
        it.mask = '0;
        for (int k = start; k <= j; k++) it.mask[k] = 1'b1;
        it.word = w;
        exp_q.push_back(it);
        start = j + 1;
      end
    end
    @(negedge clk);
    while (!fetch_req) @(negedge clk);
    fetch_valid = 1'b1;
    fetch_word  = w;
    @(posedge clk);
    #1;
    fetch_valid = 1'b0;
    fetch_word  = '0;
  endtask

  // Hold driver: inputs change 1 ns after the rising edge.
  always @(posedge clk) begin
    #1;
    if (rand_hold) hold_in <= (($urandom % 3) == 0);
    else           hold_in <= 1'b0;
  end

  // Monitor: samples on the falling edge.
  always @(negedge clk) begin
    if (mon_en) begin
      if (hold_in) begin
        checks++;
        if (lane_valid != '0) begin
          errors++;
          $display("FAIL R6: lanes valid during hold, actual %b expected %b", lane_valid, {NSLOT{1'b0}});
        end
      end else if (lane_valid != '0) begin
        checks++;
        if (fetch_req) begin
          errors++;
          $display("FAIL R5: fetch_req high while issuing, actual %b expected 0", fetch_req);
        end
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R8: unexpected execute packet, actual mask %b expected none", lane_valid);
        end else begin
          ep_item_t it;
          it = exp_q.pop_front();
          if (lane_valid != it.mask) begin
            errors++;
            $display("FAIL R2/R3/R4: lane mask actual %b expected %b", lane_valid, it.mask);
          end
          for (int k = 0; k < NSLOT; k++) begin
            if (it.mask[k] && lane_instr[k*IW +: IW] !== it.word[k*IW +: IW]) begin
              errors++;
              $display("FAIL R7: lane %0d actual %h expected %h", k,
                       lane_instr[k*IW +: IW], it.word[k*IW +: IW]);
            end
          end
        end
      end
    end
  end

  task automatic drain();
    int guard;
    guard = 0;
    while (exp_q.size() != 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8: execute packets missing, actual %0d left expected 0", exp_q.size());
    end
  endtask

  task automatic run_all();
    rst_n       = 1'b0;
    fetch_valid = 1'b0;
    fetch_word  = '0;
    hold_in     = 1'b0;
    rand_hold   = 1'b0;
    mon_en      = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (lane_valid != '0 || fetch_req !== 1'b1) begin
      errors++;
      $display("FAIL R1: in reset actual valid %b req %b expected 0 1", lane_valid, fetch_req);
    end
    @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);
    checks++;
    if (lane_valid != '0 || fetch_req !== 1'b1) begin
      errors++;
      $display("FAIL R1: after reset actual valid %b req %b expected 0 1", lane_valid, fetch_req);
    end
    mon_en = 1'b1;

    // R2: one eight-wide execute packet
    send_fp(make_fp(8'b0111_1111, 1));
    // R3: eight single-instruction packets
    send_fp(make_fp(8'b0000_0000, 2));
    // R4: final slot flag set, still ends the packet
    send_fp(make_fp(8'b1111_1111, 3));
    send_fp(make_fp(8'b1000_0001, 4));
    // R7: mixed runs
    send_fp(make_fp(8'b0110_1101, 5));
    send_fp(make_fp(8'b0011_1000, 6));
    drain();

    // R6: deterministic hold in the middle of a fetch packet
    send_fp(make_fp(8'b0000_0101, 7));
    @(posedge clk); #1 hold_in = 1'b1;
    repeat (3) @(posedge clk);
    #1 hold_in = 1'b0;
    drain();

    // R6 and R8: random chains under random hold
    rand_hold = 1'b1;
    for (int n = 0; n < 300; n++) begin
      send_fp(make_fp(8'($urandom), 100 + n));
    end
    drain();
    rand_hold = 1'b0;
  endtask

  initial begin
    checks = 0;
    errors = 0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule